// File: doc/BRIEF.md
# Partial Reconfiguration Control Engine

This block sits between a host's register bus and a fabric configuration port. Software loads a reconfiguration image into it one 32-bit word at a time through a 64-bit data register. A small internal FIFO buffers the words, and the block forwards them to a ready/valid word sink. Software sees how many FIFO slots are free as a credit count in the status register, and it pushes a word only while that count is above one.

An operation follows a fixed sequence. The host holds the engine in reset until it reads back the reset acknowledge. The host then releases reset and sets the start request. It streams the image, with a CRC-32 of the image as the last word, and then sets push-complete. The engine drains the FIFO, checks the CRC, and clears start and push-complete by itself. Faults raise sticky error flags, and software clears them by writing back the value it read.

Register word offsets on `reg_addr`: 0 control, 1 status, 2 data, 3 error, 20 interface ID low, 21 interface ID high. Writes take effect at the clock edge where `reg_we` is high. `reg_rdata` follows `reg_addr` combinationally.

Top module: `prc_engine`

## Requirements
- R1: After reset the control and error registers read 0. The status register reads the credit count equal to `FIFO_DEPTH` in bits 8:0 and zero in every other bit, and `snk_valid` is low.
- R2: Writing control bit 0 = 1 holds the engine in reset. Control bit 4 (reset acknowledge) reads 1 from the second cycle after the write and stays 1 while bit 0 is held. During reset the FIFO is flushed, so the credits return to `FIFO_DEPTH`, and status bits 27:24 read 1. Once bit 0 is cleared, bit 4 and status bits 27:24 return to 0.
- R3: Control bits 9:8 (region), bit 14 (image kind) and bits 63:32 (configuration data) read back as last written. Control bits 1-3, 5-7, 10, 11 and 15-31 read 0.
- R4: Writing control bit 12 = 1 (with bit 0 = 0) while idle sets the start request at once. Status bits 27:24 then read 2. Writing bit 12 = 0 during an operation has no effect on it.
- R5: While start is set and push-complete is clear, a data-register write with credits above zero enqueues bits 31:0 and ignores bits 63:32. Each accepted word lowers the credit count by one. Words leave on `snk_data` in push order, and each word the sink takes restores one credit.
- R6: A data write while start is clear, or after push-complete is set, sets error bit 3 (protocol), and the word never reaches the sink.
- R7: A data write during loading with zero credits sets error bit 4 (overflow) and the word is dropped.
- R8: At completion, the last accepted word is compared with the CRC-32 of all earlier words, and a mismatch sets error bit 1. The CRC uses the reflected polynomial 0xEDB88320 with all-ones initial value and final inversion, and takes each word least-significant bit first. A completion with no accepted word sets error bit 3 instead.
- R9: After push-complete (control bit 13) the engine forwards every buffered word to the sink, then clears control bits 12 and 13 by itself. Status bits 27:24 then return to 0.
- R10: Error bit 0 is set at completion if the operation had a CRC mismatch, no word, or a protocol or overflow fault raised between start and completion.
- R11: A high cycle on `snk_incompat` sets error bit 2, and a high cycle on `snk_auth_err` sets error bit 6.
- R12: Error flags are sticky. A write to the error register clears exactly the flags whose bits are 1 in the written value. Status bit 16 is the OR of all flags, and error bits 5 and 63:7 read 0.
- R13: Offsets 20 and 21 return `ID_LO` and `ID_HI` and ignore writes. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| snk_valid | output | 1 | Word available to the configuration sink |
| snk_ready | input | 1 | Sink takes the word this cycle |
| snk_data | output | 32 | Word to the sink |
| snk_incompat | input | 1 | Sink reports an incompatible image |
| snk_auth_err | input | 1 | Sink reports a failed secure load |

## Verification
The bench builds the engine with `FIFO_DEPTH` = 4. With this depth the credit count can be walked through every value from full to empty and into overflow with a handful of pushes. It sweeps image lengths of one to six words plus a CRC word, under a sink that is always ready and under one that toggles readiness. At the longer lengths the host must wait on credits, because the image is larger than the FIFO. Both interface IDs are set to distinct patterns so that a swapped or truncated readback is visible.

// File: rtl/prc_pkg.sv
// Package: shared state encoding, register offsets, error bit positions and the
// CRC-32 word update used by the partial reconfiguration control engine.
package prc_pkg;

    // Sequencer states; the encoding is reported in status bits 22:20.
    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_RESET  = 3'd1,
        SEQ_LOAD   = 3'd2,
        SEQ_DRAIN  = 3'd3,
        SEQ_FINISH = 3'd4
    } seq_state_t;

    // Register word offsets.
    localparam int OFS_CTRL  = 0;
    localparam int OFS_STAT  = 1;
    localparam int OFS_DATA  = 2;
    localparam int OFS_ERR   = 3;
    localparam int OFS_ID_LO = 20;
    localparam int OFS_ID_HI = 21;

    // Error flag positions.
    localparam int EB_OP     = 0;
    localparam int EB_CRC    = 1;
    localparam int EB_INCOMP = 2;
    localparam int EB_PROTO  = 3;
    localparam int EB_OVF    = 4;
    localparam int EB_AUTH   = 6;
    localparam int ERR_W     = 7;
    localparam logic [ERR_W-1:0] ERR_KEEP = 7'b101_1111;

    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    // One 32-bit word into a reflected CRC-32 register, bit 0 first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 32; i++) begin
            r = (r >> 1) ^ (CRC_POLY & {32{r[0] ^ d[i]}});
        end
        return r;
    endfunction

endpackage

// File: rtl/prc_fifo.sv
// Module: synchronous word FIFO holding image words between the register bus
// and the configuration sink.
// Assumes: the caller never pushes when full nor pops when empty; flush empties
// it in one cycle. DEPTH need not be a power of two.
module prc_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    assign dout  = store[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !flush));
    a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));

endmodule

// File: rtl/prc_crc_acc.sv
// Module: running CRC-32 over accepted image words, keeping the CRC of all words
// before the newest one so the newest can be checked as the trailer.
// Assumes: clear and take are never both high.
module prc_crc_acc
    import prc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        take,
    input  logic [31:0] word,
    output logic        tail_ok,
    output logic        any_word
);

    logic [31:0] run_q, prev_q, tail_q;

    // Accumulate on each accepted word; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_q    <= CRC_INIT;
            prev_q   <= CRC_INIT;
            tail_q   <= '0;
            any_word <= 1'b0;
        end else if (take) begin
            prev_q   <= run_q;
            run_q    <= crc_step(run_q, word);
            tail_q   <= word;
            any_word <= 1'b1;
        end
    end

    assign tail_ok = (tail_q == ~prev_q);

    a_r8_word_seen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (any_word && !clear) |=> any_word);

endmodule

// File: rtl/prc_seq.sv
// Module: operation sequencer - reset handshake, start, push-complete, drain
// and finish. Start and push-complete bits are derived from its state.
// Assumes: start_wr and push_wr are single-cycle write strobes.
module prc_seq
    import prc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req,
    input  logic       start_wr,
    input  logic       push_wr,
    input  logic       fifo_empty,
    output seq_state_t state,
    output logic       start_go,
    output logic       rst_ack,
    output logic       start_bit,
    output logic       push_bit
);

    seq_state_t nxt;

    assign start_go = (state == SEQ_IDLE) && start_wr && !rst_req;

    // Next-state selection; a held reset request overrides everything.
    always_comb begin
        nxt = state;
        if (rst_req) begin
            nxt = SEQ_RESET;
        end else begin
            unique case (state)
                SEQ_IDLE:   if (start_wr) nxt = SEQ_LOAD;
                SEQ_RESET:  nxt = SEQ_IDLE;
                SEQ_LOAD:   if (push_wr) nxt = SEQ_DRAIN;
                SEQ_DRAIN:  if (fifo_empty) nxt = SEQ_FINISH;
                SEQ_FINISH: nxt = SEQ_IDLE;
                default:    nxt = SEQ_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= nxt;
    end

    assign rst_ack   = (state == SEQ_RESET);
    assign start_bit = (state == SEQ_LOAD) || (state == SEQ_DRAIN) || (state == SEQ_FINISH);
    assign push_bit  = (state == SEQ_DRAIN) || (state == SEQ_FINISH);

    a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_ack);
    a_r9_load_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_LOAD) |=> (state == SEQ_LOAD || state == SEQ_DRAIN || state == SEQ_RESET));
    a_r9_start_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_bit) |-> ($past(state) == SEQ_FINISH || $past(rst_req)));

endmodule

// File: rtl/prc_engine.sv
// Module: top of the partial reconfiguration control engine - register decode,
// credit reporting, data acceptance, sticky error flags and sink interface.
// Assumes: one register access per cycle; reads are combinational on reg_addr.
module prc_engine
    import prc_pkg::*;
#(
    parameter int          FIFO_DEPTH = 16,
    parameter int          ADDR_W     = 5,
    parameter logic [63:0] ID_LO      = 64'h0,
    parameter logic [63:0] ID_HI      = 64'h0,
    localparam int         CNT_W      = $clog2(FIFO_DEPTH + 1),
    localparam int         CRED_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              snk_valid,
    input  logic              snk_ready,
    output logic [31:0]       snk_data,
    input  logic              snk_incompat,
    input  logic              snk_auth_err
);

    // Control fields held by software.
    logic        rst_req_q, kind_q;
    logic [1:0]  region_q;
    logic [31:0] cfg_q;

    seq_state_t       state;
    logic             start_go, rst_ack, start_bit, push_bit;
    logic             fifo_empty, fifo_full, take, pop, flush;
    logic [CNT_W-1:0] fifo_cnt;
    logic [CRED_W-1:0] credits;
    logic             tail_ok, any_word, crc_clear, finish;
    logic             in_load, proto_hit, ovf_hit, op_fault_q;
    logic [ERR_W-1:0] err_q, err_set, err_clr;
    logic [31:0]      fifo_dout;

    wire wr_ctl = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
    wire wr_dat = reg_we && (reg_addr == ADDR_W'(OFS_DATA));
    wire wr_err = reg_we && (reg_addr == ADDR_W'(OFS_ERR));

    wire start_wr = wr_ctl && reg_wdata[12] && !reg_wdata[0];
    wire push_wr  = wr_ctl && reg_wdata[13];

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[11:10], reg_wdata[7:1], reg_wdata[31:15]};

    // Software-owned control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
            region_q  <= '0;
            kind_q    <= 1'b0;
            cfg_q     <= '0;
        end else if (wr_ctl) begin
            rst_req_q <= reg_wdata[0];
            region_q  <= reg_wdata[9:8];
            kind_q    <= reg_wdata[14];
            cfg_q     <= reg_wdata[63:32];
        end
    end

    prc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_req    (rst_req_q),
        .start_wr   (start_wr),
        .push_wr    (push_wr),
        .fifo_empty (fifo_empty),
        .state      (state),
        .start_go   (start_go),
        .rst_ack    (rst_ack),
        .start_bit  (start_bit),
        .push_bit   (push_bit)
    );

    assign in_load   = (state == SEQ_LOAD);
    assign take      = wr_dat && in_load && !fifo_full;
    assign proto_hit = wr_dat && !in_load;
    assign ovf_hit   = wr_dat && in_load && fifo_full;
    assign flush     = (state == SEQ_RESET);
    assign finish    = (state == SEQ_FINISH);
    assign crc_clear = start_go || flush;

    prc_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (take),
        .din   (reg_wdata[31:0]),
        .pop   (pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    assign snk_valid = !fifo_empty && !flush;
    assign snk_data  = fifo_dout;
    assign pop       = snk_valid && snk_ready;
    assign credits   = CRED_W'(FIFO_DEPTH) - CRED_W'(fifo_cnt);

    prc_crc_acc u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (crc_clear),
        .take     (take),
        .word     (reg_wdata[31:0]),
        .tail_ok  (tail_ok),
        .any_word (any_word)
    );

    // Remember any push fault raised inside the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n || start_go) op_fault_q <= 1'b0;
        else if ((proto_hit || ovf_hit) && (state == SEQ_LOAD || state == SEQ_DRAIN))
            op_fault_q <= 1'b1;
    end

    // Flag set sources for this cycle.
    always_comb begin
        err_set            = '0;
        err_set[EB_PROTO]  = proto_hit || (finish && !any_word);
        err_set[EB_OVF]    = ovf_hit;
        err_set[EB_CRC]    = finish && any_word && !tail_ok;
        err_set[EB_OP]     = finish && (op_fault_q || !any_word || !tail_ok);
        err_set[EB_INCOMP] = snk_incompat;
        err_set[EB_AUTH]   = snk_auth_err;
    end

    assign err_clr = wr_err ? (reg_wdata[ERR_W-1:0] & ERR_KEEP) : '0;

    // Sticky flags: write-one-to-clear, a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= ((err_q & ~err_clr) | err_set) & ERR_KEEP;
    end

    wire [3:0] host_st = (state == SEQ_IDLE)  ? 4'd0 :
                         (state == SEQ_RESET) ? 4'd1 : 4'd2;

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_CTRL):  reg_rdata = {cfg_q, 17'b0, kind_q, push_bit, start_bit, 2'b0,
                                             region_q, 3'b0, rst_ack, 3'b0, rst_req_q};
            ADDR_W'(OFS_STAT):  reg_rdata = {36'b0, host_st, 1'b0, 3'(state), 3'b0, |err_q,
                                             7'b0, credits};
            ADDR_W'(OFS_ERR):   reg_rdata = {57'b0, err_q};
            ADDR_W'(OFS_ID_LO): reg_rdata = ID_LO;
            ADDR_W'(OFS_ID_HI): reg_rdata = ID_HI;
            default:            reg_rdata = '0;
        endcase
    end

    a_r5_credit_range: assert property (@(posedge clk) disable iff (!rst_n)
        credits <= CRED_W'(FIFO_DEPTH));
    a_r7_overflow_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |-> (credits == '0));
    a_r6_proto_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_hit && !pop && !flush) |=> (fifo_cnt == $past(fifo_cnt)));
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q & ~err_clr) != '0) |=> ((err_q & $past(err_q & ~err_clr)) == $past(err_q & ~err_clr)));

endmodule

// File: tb/tb_prc_engine.sv
module tb_prc_engine;
    localparam int DEPTH = 4;
    localparam logic [63:0] IDL = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] IDH = 64'hFEDC_BA98_7654_3210;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        snk_valid, snk_ready = 1'b0;
    logic [31:0] snk_data;
    logic        snk_incompat = 1'b0, snk_auth_err = 1'b0;

    int nchk = 0, nerr = 0, rdy_mode = 0, cap_n = 0;
    logic [31:0] cap_q [0:255];
    logic [31:0] img [0:15];
    logic        done_flag = 1'b0;

    always #2 clk = ~clk;

    prc_engine #(.FIFO_DEPTH(DEPTH), .ADDR_W(5), .ID_LO(IDL), .ID_HI(IDH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snk_valid(snk_valid),
        .snk_ready(snk_ready), .snk_data(snk_data), .snk_incompat(snk_incompat),
        .snk_auth_err(snk_auth_err));

    always @(negedge clk)
        snk_ready <= (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? ~snk_ready : 1'b0;

    always @(posedge clk)
        if (rst_n && snk_valid && snk_ready) begin
            cap_q[cap_n[7:0]] <= snk_data;
            cap_n <= cap_n + 1;
        end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [63:0] v);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 4; b++) begin
                c = c ^ {24'h0, img[i][8*b +: 8]};
                for (int k = 0; k < 8; k++)
                    c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
            end
        return ~c;
    endfunction

    task automatic push_word(input logic [31:0] w);
        logic [63:0] s;
        int g = 0;
        rd(1, s);
        while (s[8:0] <= 1 && g < 500) begin rd(1, s); g++; end
        wr(2, {32'hBAD0_C0DE, w});
    endtask

    task automatic wait_done();
        logic [63:0] c;
        int g = 0;
        rd(0, c);
        while (c[12] && g < 500) begin rd(0, c); g++; end
    endtask

    initial begin
        logic [63:0] v;
        int base, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, v); chk("R1 control", v, 64'h0);
        rd(1, v); chk("R1 status", v, 64'(DEPTH));
        rd(3, v); chk("R1 error", v, 64'h0);
        chk("R1 snk_valid", {63'h0, snk_valid}, 64'h0);
        // R13 id registers, write ignored, unmapped zero
        wr(20, 64'h1111);
        rd(20, v); chk("R13 id low", v, IDL);
        rd(21, v); chk("R13 id high", v, IDH);
        rd(10, v); chk("R13 unmapped", v, 64'h0);

        // R2 reset handshake with flush
        rdy_mode = 0;
        wr(0, 64'h1000);
        img[0] = 32'h1; img[1] = 32'h2;
        wr(2, 64'h1); wr(2, 64'h2);
        base = cap_n;
        wr(0, 64'h1);
        rd(0, v); chk("R2 ack set", {62'h0, v[4], v[12]}, 64'h2);
        rd(1, v); chk("R2 flushed credits", {55'h0, v[8:0]}, 64'(DEPTH));
        chk("R2 host in reset", {60'h0, v[27:24]}, 64'h1);
        wr(0, 64'h0);
        rd(0, v); chk("R2 ack released", {63'h0, v[4]}, 64'h0);
        rd(1, v); chk("R2 host idle", {60'h0, v[27:24]}, 64'h0);
        chk("R2 nothing sent", 64'(cap_n - base), 64'h0);

        // R3/R4 field storage, start held against a written zero
        wr(0, 64'h1000);
        rd(1, v); chk("R4 host busy", {60'h0, v[27:24]}, 64'h2);
        wr(0, 64'hA5A5_0001_FFFF_4EEE & ~64'h1001 & ~64'h3000);
        rd(0, v);
        chk("R3 R4 control readback", v, 64'hA5A5_0001_0000_0000 | 64'h4000 | 64'h1000 | 64'h0200);
        // R8 zero-word completion -> bits 3 and 0
        wr(0, 64'h3000);
        wait_done();
        rd(3, v); chk("R8 R10 zero words", v, 64'h09);
        wr(3, v);
        rd(3, v); chk("R12 cleared", v, 64'h0);

        // R5 R7 credit walk and overflow
        rdy_mode = 0;
        base = cap_n;
        wr(0, 64'h1000);
        for (int k = 0; k < DEPTH; k++) begin
            img[k] = 32'hC0DE_0000 + 32'(k * 7 + 3);
            wr(2, {32'hFFFF_FFFF, img[k]});
            rd(1, v); chk("R5 credit step", {55'h0, v[8:0]}, 64'(DEPTH - k - 1));
        end
        wr(2, 64'h5555);
        rd(3, v); chk("R7 overflow flag", v, 64'h10);
        rd(1, v); chk("R12 any flag", {63'h0, v[16]}, 64'h1);
        rdy_mode = 1;
        repeat (12) @(negedge clk);
        rd(1, v); chk("R5 credit restored", {55'h0, v[8:0]}, 64'(DEPTH));
        chk("R5 drained count", 64'(cap_n - base), 64'(DEPTH));
        bad = 0;
        for (int k = 0; k < DEPTH; k++) if (cap_q[base + k] !== img[k]) bad++;
        chk("R5 order and upper bits ignored", 64'(bad), 64'h0);
        wr(0, 64'h3000);
        wait_done();
        rd(3, v); chk("R10 R8 R7 after overflow op", v, 64'h13);
        wr(3, 64'h10);
        rd(3, v); chk("R12 partial clear", v, 64'h03);
        wr(3, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(3, v); chk("R12 full clear", v, 64'h0);

        // R6 protocol: idle write, and write after push-complete
        base = cap_n;
        wr(2, 64'h77);
        repeat (4) @(negedge clk);
        rd(3, v); chk("R6 idle data write", v, 64'h08);
        chk("R6 idle word discarded", 64'(cap_n - base), 64'h0);
        wr(3, 64'h08);
        rdy_mode = 0;
        wr(0, 64'h1000);
        wr(2, 64'h42);
        wr(0, 64'h3000);
        wr(2, 64'h99);
        rdy_mode = 1;
        wait_done();
        rd(3, v); chk("R6 R10 late write", v, 64'h0B);
        chk("R6 late word discarded", 64'(cap_n - base), 64'h1);
        wr(3, v);

        // R11 sink-reported faults
        @(negedge clk) snk_incompat = 1'b1;
        @(negedge clk) snk_incompat = 1'b0;
        rd(3, v); chk("R11 incompatible", v, 64'h04);
        @(negedge clk) snk_auth_err = 1'b1;
        @(negedge clk) snk_auth_err = 1'b0;
        wr(3, 64'h04);
        rd(3, v); chk("R11 R12 secure flag kept", v, 64'h40);
        wr(3, 64'h40);

        // R8 R9 sweep over image lengths and sink behaviour
        for (int m = 1; m <= 2; m++)
            for (int n = 1; n <= 6; n++) begin
                rdy_mode = m;
                for (int i = 0; i < n; i++) img[i] = 32'h9E37_79B9 * 32'(i + 1) ^ 32'(m * 16 + n);
                img[n] = ref_crc(n);
                base = cap_n;
                wr(0, 64'h1000);
                for (int i = 0; i <= n; i++) push_word(img[i]);
                wr(0, 64'h3000);
                wait_done();
                rd(3, v); chk("R8 good image no error", v, 64'h0);
                rd(1, v); chk("R9 idle after finish", {v[27:24], v[8:0]} , {4'h0, 9'(DEPTH)});
                chk("R9 all words sent", 64'(cap_n - base), 64'(n + 1));
                bad = 0;
                for (int i = 0; i <= n; i++) if (cap_q[base + i] !== img[i]) bad++;
                chk("R9 sink words", 64'(bad), 64'h0);
            end

        // R8 corrupt trailer
        rdy_mode = 1;
        img[0] = 32'h1234_5678; img[1] = 32'h0;
        wr(0, 64'h1000);
        push_word(img[0]); push_word(~ref_crc(1));
        wr(0, 64'h3000);
        wait_done();
        rd(3, v); chk("R8 R10 CRC mismatch", v, 64'h03);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule